// File: doc/BRIEF.md
# Forwarded Read Responder for a Private Coherent Cache

This block sits in the forward path of a private first-level cache controller that keeps lines in owner-aware coherence states. Only one forwarded request is handled at a time. The request arrives on a valid/ready port and carries:

- an address;
- the request kind, which is either a shared read or a DMA read;
- the requestor class;
- a requestor identifier.

Alongside the request, the controller presents the line's present state, the line data from the cache array, and the pending-eviction buffer together with its valid bit. The block does not change the line state.

For each request the block sends zero, one or two responses on a single valid/ready response port. The data response goes to the requestor. For a DMA read it is followed by a control-sized acknowledgement addressed to the second-level cache slice that owns the address. The slice index is taken from a parameterised address bit field. In the eviction states, the data is taken from the eviction buffer instead of the array. A request that is not legal in the presented state raises a one-cycle error flag and is dropped.

Back-pressure rules:
- The requestor must hold the request and its side inputs stable while `fwd_valid` is high.
- The block holds a response and all of its fields stable while `out_valid` is high and `out_ready` is low.
- `fwd_ready` rises only in the cycle in which the last response of the request is accepted. For a request that produces no response, it rises at once.

Top module: `fwd_read_responder`

## Requirements
- R1: A shared read (`fwd_kind`=0) in state S(1), O(2), SM(5) or OM(6) produces exactly one DATA response (`out_kind`=0) carrying `line_data`. No acknowledgement follows.
- R2: A DMA read (`fwd_kind`=1) in state S, O, M(3), MM(4), SM or OM produces a DATA response carrying `line_data`. The DMA acknowledgement (`out_kind`=1) follows in a later cycle. The request is popped in the cycle the acknowledgement is accepted.
- R3: In the eviction states MI(7), SI(8) and OI(9), when the requestor class is first-level cache (0) or DMA engine (1), the data response carries `evict_data` in place of `line_data`.
- R4: In an eviction state with requestor class 2 or 3, no data response is sent. A DMA read still sends its acknowledgement. A shared read is popped with no response and no error.
- R5: An acknowledgement has `out_acks`=1, `out_dirty`=0, `out_ctrl`=1, `out_to_l2`=1, `out_data`=0. Its `out_dest` equals `fwd_addr[SLICE_LOW +: SLICE_BITS]`.
- R6: A data response has `out_to_l2`=0, `out_acks`=0, `out_ctrl`=0 and `out_dest`=`fwd_id`. Its `out_dirty` is 1 exactly in states O, M, MM, OM, MI and OI.
- R7: Every response carries `out_sender`=MY_ID, `out_lat`=REQ_LAT and `out_addr`=`fwd_addr`.
- R8: A request in a state where its kind is not accepted is popped in its first cycle with `fault`=1 and no response. This covers state I(0), codes 10 to 15, and a shared read in M or MM.
- R9: A request in an eviction state whose requestor class is 0 or 1 while `evict_valid`=0 is popped with `fault`=1 and no response.
- R10: While `out_valid`=1 and `out_ready`=0, the same response stays presented. `fwd_ready` is 0 until the last response is accepted.
- R11: With `fwd_valid` low after reset, `out_valid`, `fwd_ready` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_ready | output | 1 | Request popped this cycle |
| fwd_addr | input | ADDR_W | Line address |
| fwd_kind | input | 1 | 0 shared read, 1 DMA read |
| fwd_class | input | 2 | 0 L1 cache, 1 DMA engine, 2 L2, 3 directory |
| fwd_id | input | ID_W | Requestor identifier |
| line_state | input | 4 | Present line state code |
| line_data | input | DATA_W | Line data from the cache array |
| evict_valid | input | 1 | Eviction buffer entry valid |
| evict_data | input | DATA_W | Eviction buffer data |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Response accepted |
| out_kind | output | 1 | 0 DATA, 1 DMA acknowledgement |
| out_addr | output | ADDR_W | Response address |
| out_data | output | DATA_W | Response data |
| out_dest | output | DEST_W | Requestor id or L2 slice index |
| out_to_l2 | output | 1 | Destination is an L2 slice |
| out_dirty | output | 1 | Dirty flag |
| out_acks | output | ACK_W | Ack count |
| out_ctrl | output | 1 | Control-sized message |
| out_sender | output | ID_W | Sender identity of this cache |
| out_lat | output | LAT_W | Request-latency tag |
| fault | output | 1 | Illegal request dropped this cycle |

## Verification
The assertions assume that the request and its side inputs stay constant while `fwd_valid` is high. Hold and ordering checks are only meaningful when that is true. The bench drives a new request only after the handshake on the previous one, so it never changes a presented request. It sweeps every state code, kind, requestor class and buffer-valid value. Each combination is run twice: once with the response port always ready, and once with it stalled on alternate cycles. The stalled run exercises holding a response both before the data response and between the data response and the acknowledgement.

// File: rtl/fwdr_pkg.sv
package fwdr_pkg;

  typedef enum logic [3:0] {
    LS_I  = 4'd0,
    LS_S  = 4'd1,
    LS_O  = 4'd2,
    LS_M  = 4'd3,
    LS_MM = 4'd4,
    LS_SM = 4'd5,
    LS_OM = 4'd6,
    LS_MI = 4'd7,
    LS_SI = 4'd8,
    LS_OI = 4'd9
  } line_state_e;

  localparam logic KIND_SHARED = 1'b0;
  localparam logic KIND_DMA    = 1'b1;

  localparam logic [1:0] CLS_L1  = 2'd0;
  localparam logic [1:0] CLS_DMA = 2'd1;

  localparam logic RSP_DATA = 1'b0;
  localparam logic RSP_ACK  = 1'b1;

  typedef struct packed {
    logic from_evict;
    logic want_data;
    logic want_ack;
    logic dirty;
    logic fault;
  } plan_t;

endpackage

// File: rtl/fwdr_classify.sv
module fwdr_classify
  import fwdr_pkg::*;
(
  input  logic [3:0] state,
  input  logic       kind,
  input  logic [1:0] cls,
  input  logic       evict_valid,
  output plan_t      plan
);

  logic array_shared_ok;
  logic array_dma_ok;
  logic evict_st;
  logic accepted;
  logic cls_gets_data;
  logic no_buffer;

  always_comb begin
    array_shared_ok = 1'b0;
    array_dma_ok    = 1'b0;
    evict_st        = 1'b0;
    plan.dirty      = 1'b0;
    case (state)
      LS_S, LS_SM: begin
        array_shared_ok = 1'b1;
        array_dma_ok    = 1'b1;
      end
      LS_O, LS_OM: begin
        array_shared_ok = 1'b1;
        array_dma_ok    = 1'b1;
        plan.dirty      = 1'b1;
      end
      LS_M, LS_MM: begin
        array_dma_ok = 1'b1;
        plan.dirty   = 1'b1;
      end
      LS_MI, LS_OI: begin
        evict_st   = 1'b1;
        plan.dirty = 1'b1;
      end
      LS_SI: evict_st = 1'b1;
      default: ;
    endcase
  end

  assign accepted      = evict_st | ((kind == KIND_DMA) ? array_dma_ok : array_shared_ok);
  assign cls_gets_data = (cls == CLS_L1) | (cls == CLS_DMA);
  assign no_buffer     = evict_st & cls_gets_data & ~evict_valid;

  assign plan.from_evict = evict_st;
  assign plan.fault      = ~accepted | no_buffer;
  assign plan.want_data  = accepted & ~no_buffer & (~evict_st | cls_gets_data);
  assign plan.want_ack   = accepted & ~no_buffer & (kind == KIND_DMA);

endmodule

// File: rtl/fwdr_route.sv
module fwdr_route #(
  parameter int ID_W       = 4,
  parameter int SLICE_BITS = 2,
  parameter int DEST_W     = 4
) (
  input  logic                  is_ack,
  input  logic [ID_W-1:0]       req_id,
  input  logic [SLICE_BITS-1:0] slice_field,
  output logic [DEST_W-1:0]     dest,
  output logic                  to_l2
);

  logic [DEST_W-1:0] slice_wide;
  logic [DEST_W-1:0] id_wide;

  assign slice_wide = DEST_W'(slice_field);
  assign id_wide    = DEST_W'(req_id);
  assign dest       = is_ack ? slice_wide : id_wide;
  assign to_l2      = is_ack;

endmodule

// File: rtl/fwdr_sequencer.sv
module fwdr_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic want_data,
  input  logic want_ack,
  input  logic bad_req,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_is_ack,
  output logic req_ready,
  output logic err
);

  logic ack_phase_q;
  logic has_any;
  logic last_rsp;
  logic rsp_fire;

  assign has_any    = want_data | want_ack;
  assign rsp_is_ack = ack_phase_q | ~want_data;
  assign last_rsp   = rsp_is_ack | ~want_ack;
  assign rsp_valid  = req_valid & ~bad_req & has_any;
  assign rsp_fire   = rsp_valid & rsp_ready;
  assign req_ready  = req_valid & (bad_req | ~has_any | (rsp_fire & last_rsp));
  assign err        = req_valid & bad_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_phase_q <= 1'b0;
    end else if (req_ready) begin
      ack_phase_q <= 1'b0;
    end else if (rsp_fire && !last_rsp) begin
      ack_phase_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fwd_read_responder.sv
module fwd_read_responder
  import fwdr_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          ID_W       = 4,
  parameter int          SLICE_LOW  = 6,
  parameter int          SLICE_BITS = 2,
  parameter int          ACK_W      = 4,
  parameter int          LAT_W      = 4,
  parameter logic [3:0]  MY_ID      = 4'd9,
  parameter int          REQ_LAT    = 3,
  localparam int         DEST_W     = (ID_W > SLICE_BITS) ? ID_W : SLICE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_valid,
  output logic              fwd_ready,
  input  logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_kind,
  input  logic [1:0]        fwd_class,
  input  logic [ID_W-1:0]   fwd_id,
  input  logic [3:0]        line_state,
  input  logic [DATA_W-1:0] line_data,
  input  logic              evict_valid,
  input  logic [DATA_W-1:0] evict_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic              out_to_l2,
  output logic              out_dirty,
  output logic [ACK_W-1:0]  out_acks,
  output logic              out_ctrl,
  output logic [ID_W-1:0]   out_sender,
  output logic [LAT_W-1:0]  out_lat,
  output logic              fault
);

  plan_t                 plan;
  logic                  is_ack;
  logic [SLICE_BITS-1:0] slice_field;
  logic [DATA_W-1:0]     src_data;

  fwdr_classify u_classify (
    .state       (line_state),
    .kind        (fwd_kind),
    .cls         (fwd_class),
    .evict_valid (evict_valid),
    .plan        (plan)
  );

  fwdr_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (fwd_valid),
    .want_data  (plan.want_data),
    .want_ack   (plan.want_ack),
    .bad_req    (plan.fault),
    .rsp_ready  (out_ready),
    .rsp_valid  (out_valid),
    .rsp_is_ack (is_ack),
    .req_ready  (fwd_ready),
    .err        (fault)
  );

  assign slice_field = fwd_addr[SLICE_LOW +: SLICE_BITS];

  fwdr_route #(
    .ID_W       (ID_W),
    .SLICE_BITS (SLICE_BITS),
    .DEST_W     (DEST_W)
  ) u_route (
    .is_ack      (is_ack),
    .req_id      (fwd_id),
    .slice_field (slice_field),
    .dest        (out_dest),
    .to_l2       (out_to_l2)
  );

  assign src_data   = plan.from_evict ? evict_data : line_data;
  assign out_kind   = is_ack ? RSP_ACK : RSP_DATA;
  assign out_addr   = fwd_addr;
  assign out_data   = is_ack ? '0 : src_data;
  assign out_dirty  = ~is_ack & plan.dirty;
  assign out_acks   = is_ack ? ACK_W'(1) : '0;
  assign out_ctrl   = is_ack;
  assign out_sender = ID_W'(MY_ID);
  assign out_lat    = LAT_W'(REQ_LAT);

endmodule

// File: rtl/fwdr_checker.sv
module fwdr_checker #(
  parameter int         DATA_W = 32,
  parameter int         ID_W   = 4,
  parameter int         DEST_W = 4,
  parameter int         ACK_W  = 4,
  parameter logic [3:0] MY_ID  = 4'd9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic              fwd_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_kind,
  input logic [DATA_W-1:0] out_data,
  input logic [DEST_W-1:0] out_dest,
  input logic              out_to_l2,
  input logic              out_dirty,
  input logic [ACK_W-1:0]  out_acks,
  input logic              out_ctrl,
  input logic [ID_W-1:0]   out_sender,
  input logic              fault
);

  a_r1_shared_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fwd_kind == 1'b0 |-> out_kind == 1'b0);

  a_r2_ack_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind == 1'b0 && fwd_kind == 1'b1 && !fwd_ready
    |=> out_valid && out_kind == 1'b1);

  a_r5_ack_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind |-> out_acks == ACK_W'(1) && !out_dirty && out_to_l2 && out_ctrl
                              && out_data == '0);

  a_r6_data_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_kind |-> !out_to_l2 && out_acks == '0 && !out_ctrl);

  a_r7_sender_id: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sender == ID_W'(MY_ID));

  a_r8_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !out_valid && fwd_ready);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_data)
                                && $stable(out_dest));

  a_r10_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready |-> fwd_valid);

endmodule

bind fwd_read_responder fwdr_checker #(
  .DATA_W (DATA_W),
  .ID_W   (ID_W),
  .DEST_W (DEST_W),
  .ACK_W  (ACK_W),
  .MY_ID  (MY_ID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fwd_valid  (fwd_valid),
  .fwd_ready  (fwd_ready),
  .fwd_kind   (fwd_kind),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_kind   (out_kind),
  .out_data   (out_data),
  .out_dest   (out_dest),
  .out_to_l2  (out_to_l2),
  .out_dirty  (out_dirty),
  .out_acks   (out_acks),
  .out_ctrl   (out_ctrl),
  .out_sender (out_sender),
  .fault      (fault)
);

// File: tb/fwd_read_responder_tb.sv
module fwd_read_responder_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int DEST_W = 4;
  localparam int ACK_W  = 4;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fwd_valid = 1'b0;
  logic              fwd_ready;
  logic [ADDR_W-1:0] fwd_addr = '0;
  logic              fwd_kind = 1'b0;
  logic [1:0]        fwd_class = '0;
  logic [ID_W-1:0]   fwd_id = '0;
  logic [3:0]        line_state = '0;
  logic [DATA_W-1:0] line_data = '0;
  logic              evict_valid = 1'b0;
  logic [DATA_W-1:0] evict_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_kind;
  logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data;
  logic [DEST_W-1:0] out_dest;
  logic              out_to_l2;
  logic              out_dirty;
  logic [ACK_W-1:0]  out_acks;
  logic              out_ctrl;
  logic [ID_W-1:0]   out_sender;
  logic [LAT_W-1:0]  out_lat;
  logic              fault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fwd_read_responder u_dut (
    .clk(clk), .rst_n(rst_n),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_kind(fwd_kind), .fwd_class(fwd_class), .fwd_id(fwd_id),
    .line_state(line_state), .line_data(line_data),
    .evict_valid(evict_valid), .evict_data(evict_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_data(out_data), .out_dest(out_dest),
    .out_to_l2(out_to_l2), .out_dirty(out_dirty), .out_acks(out_acks),
    .out_ctrl(out_ctrl), .out_sender(out_sender), .out_lat(out_lat),
    .fault(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_case(input int st, input int kd, input int cl, input int ev,
                          input int stall, input int n);
    bit is_ev, arr_sh, arr_dma, acc, getd, nobuf, e_fault, e_data, e_ack, e_dirty;
    int e_n, idx, cyc;
    bit done;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] ld, ed, e_dat;
    logic [ID_W-1:0] id;
    bit cur_ack;

    a  = ADDR_W'(n * 16'h0153 + 16'h0041);
    ld = 32'hA000_0000 | DATA_W'(n);
    ed = 32'hE000_0000 | DATA_W'(n);
    id = ID_W'(n % 16);

    is_ev   = (st >= 7 && st <= 9);
    arr_sh  = (st == 1 || st == 2 || st == 5 || st == 6);
    arr_dma = arr_sh || st == 3 || st == 4;
    acc     = is_ev || (kd == 1 ? arr_dma : arr_sh);
    getd    = (cl <= 1);
    nobuf   = is_ev && getd && (ev == 0);
    e_fault = !acc || nobuf;
    e_data  = acc && !nobuf && (!is_ev || getd);
    e_ack   = acc && !nobuf && (kd == 1);
    e_dirty = (st == 2 || st == 3 || st == 4 || st == 6 || st == 7 || st == 9);
    e_n     = int'(e_data) + int'(e_ack);
    e_dat   = is_ev ? ed : ld;

    fwd_valid   = 1'b1;
    fwd_addr    = a;
    fwd_kind    = kd[0];
    fwd_class   = cl[1:0];
    fwd_id      = id;
    line_state  = st[3:0];
    line_data   = ld;
    evict_valid = ev[0];
    evict_data  = ed;

    idx = 0;
    cyc = 0;
    done = 0;
    while (!done && cyc < 8) begin
      out_ready = (stall != 0) ? cyc[0] : 1'b1;
      @(negedge clk);
      if (out_valid) begin
        chk(idx < e_n, "R8/R9 unexpected response", 64'(idx), 64'(e_n));
        cur_ack = (idx > 0) || !e_data;
        chk(out_kind == cur_ack, (kd == 0) ? "R1 kind" : "R2 kind order", 64'(out_kind), 64'(cur_ack));
        if (!cur_ack) begin
          chk(out_data == e_dat, is_ev ? "R3 evict data" : "R1 array data", 64'(out_data), 64'(e_dat));
          chk(out_dest == DEST_W'(id) && !out_to_l2, "R6 data dest", 64'(out_dest), 64'(id));
          chk(out_dirty == e_dirty && out_acks == 0 && !out_ctrl, "R6 data flags",
              {out_dirty, out_acks, out_ctrl}, {e_dirty, 4'd0, 1'b0});
        end else begin
          chk(out_dest == DEST_W'((a >> 6) & 16'h3) && out_to_l2, "R5 ack slice",
              64'(out_dest), 64'((a >> 6) & 16'h3));
          chk(out_acks == 1 && !out_dirty && out_ctrl && out_data == 0, "R5 ack fields",
              {out_acks, out_dirty, out_ctrl}, {4'd1, 1'b0, 1'b1});
        end
        chk(out_sender == 4'd9 && out_lat == 4'd3 && out_addr == a, "R7 common fields",
            {out_sender, out_lat, out_addr}, {4'd9, 4'd3, a});
        if (out_ready) idx++;
      end else if (!fwd_ready) begin
        chk(1'b0, "R10 stalled without response", 64'(idx), 64'(e_n));
      end
      if (fwd_ready) begin
        done = 1;
        chk(idx == e_n, is_ev ? "R4 response count" : "R10 pop timing", 64'(idx), 64'(e_n));
        chk(fault == e_fault, nobuf ? "R9 fault" : "R8 fault", 64'(fault), 64'(e_fault));
      end
      @(posedge clk);
      #1;
      cyc++;
    end
    if (!done) chk(1'b0, "R10 never popped", 64'(idx), 64'(e_n));
    fwd_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    int n;
    n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !fwd_ready && !fault, "R11 reset state",
        {out_valid, fwd_ready, fault}, 64'd0);
    @(posedge clk);
    #1;
    for (int stall = 0; stall < 2; stall++)
      for (int st = 0; st < 16; st++)
        for (int kd = 0; kd < 2; kd++)
          for (int cl = 0; cl < 4; cl++)
            for (int ev = 0; ev < 2; ev++) begin
              run_case(st, kd, cl, ev, stall, n);
              n++;
            end
    @(negedge clk);
    chk(!out_valid && !fwd_ready && !fault, "R11 idle after sweep",
        {out_valid, fwd_ready, fault}, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule